// File: doc/BRIEF.md
# Segment Table Translation Unit

This block turns a logical address into a physical one. The logical address has two parts: a segment number and an offset into that segment. A request also names the kind of access: data read, data write or instruction fetch. The segment table lives in ordinary memory. Its start address comes from a table-base input, and the number of segments it holds comes from a table-length input. Each segment has a 64-bit descriptor in that table. A descriptor gives the segment's physical start, its length in bytes, a valid flag and three permission flags.

A request is accepted with a valid/ready handshake. The segment number is first checked against the table length. If it is in range, the unit reads the two descriptor words through a single-outstanding memory read port. It then checks, in a fixed order, the valid flag, the offset against the limit, and the permission for the requested access. The result is a one-cycle done pulse. The pulse comes with a 2-bit fault code and, on success, the physical address. The unit handles one request at a time. Loading descriptors into memory and acting on faults belong to the surrounding system.

Top module: `seg_xlate`

## Requirements
- R1: After a synchronous active-low reset, `req_ready_o` is 1, `done_o` is 0 and `mem_rd_o` is 0.
- R2: A request whose segment number is not strictly less than `tbl_len_i` finishes with fault code 1. It issues no memory read, and `done_o` rises in the cycle after acceptance.
- R3: For an in-range segment number s, exactly two reads are made. The first is at `tbl_base_i + 8*s` and returns the base (bits 31:0 of the descriptor). The second is at that address plus 4. In that second word, bits 19:0 are the limit, bit 20 is valid, bit 21 allows read, bit 22 allows write and bit 23 allows execute.
- R4: A descriptor with the valid bit at 0 gives fault code 2. This code takes precedence over any offset or permission problem.
- R5: A valid descriptor with offset greater than or equal to the limit gives fault code 3. A limit of 0 therefore rejects every offset.
- R6: Access code 0 needs the read bit, 1 needs the write bit and 2 needs the execute bit. Code 3 is reserved and always gives fault code 3. A required bit that is clear gives fault code 3.
- R7: When every check passes, the fault code is 0 and `pa_o` is base plus offset, modulo 2^32.
- R8: When the fault code is not 0, `pa_o` is 0.
- R9: `done_o` is high for exactly one cycle per request. `req_ready_o` is low from acceptance until after the done cycle. Request inputs presented during that time are ignored.
- R10: Once `mem_rd_o` is raised, it stays high and `mem_addr_o` stays unchanged until `mem_rvalid_i` returns the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_base_i | input | ADDR_W | Physical address of segment table entry 0 |
| tbl_len_i | input | SEG_W+1 | Number of segments in the table |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Unit idle, request taken when valid |
| req_seg_i | input | SEG_W | Segment number |
| req_off_i | input | OFF_W | Offset into the segment |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| mem_rd_o | output | 1 | Memory read request, held until data returns |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 2 | 0 ok, 1 segment out of range, 2 invalid segment, 3 bounds or permission |
| pa_o | output | ADDR_W | Physical address, zero on a fault |

## Verification
The assertions assume the following about the memory port:
- It returns data only while `mem_rd_o` is high.
- It answers each read once.
- It keeps `mem_rdata_i` meaningful whenever `mem_rvalid_i` is high.

The bench memory model raises `mem_rvalid_i` for a single cycle, and only after it has seen the read request for a set latency. Two latencies are used. The bench drives `tbl_base_i` and `tbl_len_i` constant for the whole run, so the range check and address arithmetic see stable table registers. It also deliberately holds altered request fields on the inputs while the unit is busy.

// File: rtl/seg_xlate_pkg.sv
// Shared types for the segment translation unit.
// Assumes a 64-bit descriptor split into two 32-bit memory words.
package seg_xlate_pkg;
    localparam int WORD_W  = 32;
    localparam int LIM_W   = 20;
    localparam int ENT_SH  = 3;   // 8 bytes per descriptor

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_RANGE   = 2'd1,
        FLT_INVALID = 2'd2,
        FLT_ACCESS  = 2'd3
    } flt_e;

    typedef struct packed {
        logic [WORD_W-1:0] base;
        logic [7:0]        rsvd;
        logic              ex;
        logic              wr;
        logic              rd;
        logic              vld;
        logic [LIM_W-1:0]  limit;
    } desc_t;
endpackage

// File: rtl/seg_desc_fetch.sv
// Reads one 64-bit descriptor as two 32-bit words, low word first.
// Assumes one outstanding read; the memory answers with a one-cycle rvalid.
module seg_desc_fetch
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] tbl_base_i,
    input  logic [SEG_W-1:0]  seg_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic [WORD_W-1:0] word0_o,
    output logic [WORD_W-1:0] word1_o,
    output logic              done_o
);
    typedef enum logic [1:0] {F_IDLE, F_LO, F_HI} fst_e;
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(WORD_W / 8);

    fst_e              state;
    logic [ADDR_W-1:0] addr_q;

    // Sequence the two reads and capture each returned word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= F_IDLE;
            addr_q  <= '0;
            word0_o <= '0;
            word1_o <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                F_IDLE: if (start_i) begin
                    addr_q <= tbl_base_i + (ADDR_W'(seg_i) << ENT_SH);
                    state  <= F_LO;
                end
                F_LO: if (mem_rvalid_i) begin
                    word0_o <= mem_rdata_i;
                    addr_q  <= addr_q + WORD_STEP;
                    state   <= F_HI;
                end
                F_HI: if (mem_rvalid_i) begin
                    word1_o <= mem_rdata_i;
                    done_o  <= 1'b1;
                    state   <= F_IDLE;
                end
                default: state <= F_IDLE;
            endcase
        end
    end

    assign mem_rd_o   = (state != F_IDLE);
    assign mem_addr_o = addr_q;

    // R10: a pending read keeps its request and address.
    p_hold_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && !mem_rvalid_i) |=> (mem_rd_o && $stable(mem_addr_o)));

    // R3: the second read is one word above the first.
    p_second_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == F_LO && mem_rvalid_i) |=> (mem_addr_o == $past(mem_addr_o) + WORD_STEP));
endmodule

// File: rtl/seg_desc_check.sv
// Evaluates a fetched descriptor against offset and access kind.
// Pure logic; the segment range check is done earlier by the caller.
module seg_desc_check
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 20
) (
    input  logic [WORD_W-1:0] word0_i,
    input  logic [WORD_W-1:0] word1_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [1:0]        acc_i,
    output logic [1:0]        fault_o,
    output logic [ADDR_W-1:0] pa_o
);
    desc_t d;
    logic  perm_ok;
    logic  in_bounds;

    assign d = {word0_i, word1_i};

    // Pick the permission bit that the access kind needs.
    always_comb begin
        case (acc_i)
            ACC_READ:  perm_ok = d.rd;
            ACC_WRITE: perm_ok = d.wr;
            ACC_EXEC:  perm_ok = d.ex;
            default:   perm_ok = 1'b0;
        endcase
    end

    assign in_bounds = (32'(off_i) < 32'(d.limit));

    // Report the first failing check in priority order.
    always_comb begin
        if (!d.vld)                       fault_o = FLT_INVALID;
        else if (!in_bounds || !perm_ok)  fault_o = FLT_ACCESS;
        else                              fault_o = FLT_NONE;
    end

    assign pa_o = ADDR_W'(d.base) + ADDR_W'(off_i);
endmodule

// File: rtl/seg_xlate.sv
// Segment translation top: takes a request, checks the segment number against
// the table length, fetches the descriptor and reports fault code and address.
// Assumes table base and length stay stable while a request is in flight.
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEG_W  = 8,
    parameter int OFF_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] tbl_base_i,
    input  logic [SEG_W:0]    tbl_len_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [SEG_W-1:0]  req_seg_i,
    input  logic [OFF_W-1:0]  req_off_i,
    input  logic [1:0]        req_acc_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [31:0]       mem_rdata_i,
    output logic              done_o,
    output logic [1:0]        fault_o,
    output logic [ADDR_W-1:0] pa_o
);
    typedef enum logic [1:0] {T_IDLE, T_FETCH, T_DONE} tst_e;

    tst_e              state;
    logic [OFF_W-1:0]  off_q;
    logic [1:0]        acc_q;
    logic              accept;
    logic              in_range;
    logic              fetch_done;
    logic [WORD_W-1:0] w0, w1;
    logic [1:0]        chk_fault;
    logic [ADDR_W-1:0] chk_pa;

    assign req_ready_o = (state == T_IDLE);
    assign accept      = req_valid_i && req_ready_o;
    assign in_range    = ({1'b0, req_seg_i} < tbl_len_i);

    seg_desc_fetch #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (accept && in_range),
        .tbl_base_i   (tbl_base_i),
        .seg_i        (req_seg_i),
        .mem_rd_o     (mem_rd_o),
        .mem_addr_o   (mem_addr_o),
        .mem_rvalid_i (mem_rvalid_i),
        .mem_rdata_i  (mem_rdata_i),
        .word0_o      (w0),
        .word1_o      (w1),
        .done_o       (fetch_done)
    );

    seg_desc_check #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_check (
        .word0_i (w0),
        .word1_i (w1),
        .off_i   (off_q),
        .acc_i   (acc_q),
        .fault_o (chk_fault),
        .pa_o    (chk_pa)
    );

    // Control flow plus latching of request fields and the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= T_IDLE;
            off_q   <= '0;
            acc_q   <= '0;
            done_o  <= 1'b0;
            fault_o <= FLT_NONE;
            pa_o    <= '0;
        end else begin
            done_o <= 1'b0;
            case (state)
                T_IDLE: if (accept) begin
                    off_q <= req_off_i;
                    acc_q <= req_acc_i;
                    if (in_range) begin
                        state <= T_FETCH;
                    end else begin
                        fault_o <= FLT_RANGE;
                        pa_o    <= '0;
                        done_o  <= 1'b1;
                        state   <= T_DONE;
                    end
                end
                T_FETCH: if (fetch_done) begin
                    fault_o <= chk_fault;
                    pa_o    <= (chk_fault == FLT_NONE) ? chk_pa : '0;
                    done_o  <= 1'b1;
                    state   <= T_DONE;
                end
                default: state <= T_IDLE;
            endcase
        end
    end

    // R2: out-of-range request completes next cycle without memory traffic.
    p_range_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_range) |=> (done_o && fault_o == FLT_RANGE && !mem_rd_o));

    // R9: completion is a single-cycle pulse.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: no new request is taken while memory is being read.
    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> !req_ready_o);

    // R8: a faulting result carries no address.
    p_fault_pa_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o != FLT_NONE) |-> (pa_o == '0));

    // R5: a passing descriptor check implies the offset is inside the limit.
    p_in_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_done && chk_fault == FLT_NONE) |-> (32'(off_q) < 32'(w1[LIM_W-1:0])));
endmodule

// File: tb/seg_xlate_bench.sv
// Sweeps every segment number of a 4-bit configuration, four offsets and
// four access kinds, at two memory latencies; expected results are computed here.
module seg_xlate_bench;
    localparam int ADDR_W = 32;
    localparam int SEG_W  = 4;
    localparam int OFF_W  = 20;
    localparam logic [31:0] TBL = 32'h0000_4000;
    localparam logic [SEG_W:0] NSEG = 5'd12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [SEG_W-1:0]  req_seg = '0;
    logic [OFF_W-1:0]  req_off = '0;
    logic [1:0]        req_acc = '0;
    logic              mem_rd;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rvalid = 1'b0;
    logic [31:0]       mem_rdata = '0;
    logic              done;
    logic [1:0]        fault;
    logic [ADDR_W-1:0] pa;

    int checks = 0;
    int fails  = 0;
    int lat    = 1;
    int wait_cnt = 0;
    int reads_total = 0;
    int stall_bad = 0;
    logic [31:0] last_addr = '0, prev_addr = '0;
    logic        p_hold = 1'b0;
    logic [31:0] p_addr = '0;

    always #2 clk = ~clk;

    seg_xlate #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .OFF_W(OFF_W)) u_seg_xlate (
        .clk(clk), .rst_n(rst_n), .tbl_base_i(TBL), .tbl_len_i(NSEG),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_seg_i(req_seg),
        .req_off_i(req_off), .req_acc_i(req_acc), .mem_rd_o(mem_rd),
        .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
        .done_o(done), .fault_o(fault), .pa_o(pa)
    );

    function automatic logic [31:0] d_base(input int s);
        return 32'(s) * 32'h1234_5678 + 32'hF000_0000;
    endfunction
    function automatic logic [19:0] d_lim(input int s);
        return (s == 3) ? 20'd0 : 20'(s * 3 + 1);
    endfunction
    function automatic logic d_vld(input int s);
        return s != 5;
    endfunction
    function automatic logic [2:0] d_perm(input int s);   // bit0 rd, bit1 wr, bit2 ex
        return 3'((s * 5 + 3) % 8);
    endfunction
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        int s;
        s = int'((a - TBL) >> 3);
        if (a[2]) return {8'h00, d_perm(s)[2], d_perm(s)[1], d_perm(s)[0], d_vld(s), d_lim(s)};
        return d_base(s);
    endfunction

    // Memory model: answers a held read after lat cycles, one-cycle rvalid.
    always @(posedge clk) begin
        if (mem_rvalid) begin
            mem_rvalid <= 1'b0;
            wait_cnt   <= 0;
        end else if (mem_rd) begin
            if (wait_cnt == lat - 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem_word(mem_addr);
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    // Read monitor and hold monitor (R3, R10).
    always @(posedge clk) begin
        if (mem_rd && mem_rvalid) begin
            reads_total <= reads_total + 1;
            prev_addr   <= last_addr;
            last_addr   <= mem_addr;
        end
        if (rst_n && p_hold && (!mem_rd || mem_addr != p_addr)) stall_bad <= stall_bad + 1;
        p_hold <= rst_n && mem_rd && !mem_rvalid;
        p_addr <= mem_addr;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input int s, input logic [19:0] off, input logic [1:0] acc);
        int snap, cyc, nrd;
        logic [1:0] ef;
        logic [31:0] ep;
        bit ready_bad;
        snap = reads_total;
        @(negedge clk);
        req_valid = 1'b1; req_seg = SEG_W'(s); req_off = off; req_acc = acc;
        @(negedge clk);
        req_seg = ~SEG_W'(s); req_off = ~off; req_acc = acc ^ 2'd1;   // R9 junk while busy
        cyc = 0; ready_bad = 0;
        while (!done && cyc < 60) begin
            if (req_ready) ready_bad = 1;
            @(negedge clk); cyc++;
        end
        if (s >= int'(NSEG))          ef = 2'd1;
        else if (!d_vld(s))           ef = 2'd2;
        else if (off >= d_lim(s))     ef = 2'd3;
        else if (acc == 2'd3)         ef = 2'd3;
        else if (!d_perm(s)[acc])     ef = 2'd3;
        else                          ef = 2'd0;
        ep = (ef == 2'd0) ? d_base(s) + 32'(off) : 32'd0;
        check(cyc < 60, "R9 done within bound", 64'(cyc), 64'd60);
        check(!ready_bad && !req_ready, "R9 ready low while busy", 64'(ready_bad), 64'd0);
        check(fault == ef, (ef == 2'd1) ? "R2 fault code" : (ef == 2'd2) ? "R4 fault code" :
              (ef == 2'd0) ? "R7 fault code" : "R5/R6 fault code", 64'(fault), 64'(ef));
        check(pa == ep, (ef == 2'd0) ? "R7 physical address" : "R8 zero address", 64'(pa), 64'(ep));
        req_valid = 1'b0;
        @(negedge clk);
        check(!done, "R9 single-cycle done", 64'(done), 64'd0);
        nrd = reads_total - snap;
        if (s >= int'(NSEG)) begin
            check(nrd == 0, "R2 no memory read", 64'(nrd), 64'd0);
            check(cyc == 0, "R2 done one cycle after accept", 64'(cyc), 64'd0);
        end else begin
            check(nrd == 2, "R3 two reads", 64'(nrd), 64'd2);
            check(prev_addr == TBL + 32'(s) * 8, "R3 first address", 64'(prev_addr), 64'(TBL + 32'(s) * 8));
            check(last_addr == prev_addr + 4, "R3 second address", 64'(last_addr), 64'(prev_addr + 4));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready && !done && !mem_rd, "R1 reset state",
              64'({req_ready, done, mem_rd}), 64'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !done && !mem_rd, "R1 idle after reset",
              64'({req_ready, done, mem_rd}), 64'b100);
        for (int l = 0; l < 2; l++) begin
            lat = (l == 0) ? 1 : 3;
            for (int s = 0; s < 16; s++) begin
                for (int o = 0; o < 4; o++) begin
                    for (int a = 0; a < 4; a++) begin
                        logic [19:0] off;
                        case (o)
                            0: off = 20'd0;
                            1: off = (d_lim(s) == 0) ? 20'd0 : d_lim(s) - 20'd1;
                            2: off = d_lim(s);
                            default: off = 20'hFFFFF;
                        endcase
                        run(s, off, 2'(a));
                    end
                end
            end
        end
        check(stall_bad == 0, "R10 held read request", 64'(stall_bad), 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule